// File: doc/BRIEF.md
# Scanline-Paced Table Register Writer

This block is one channel of a raster-effect engine. Once per frame it walks a byte table in memory. During the horizontal blanking gap that closes each scanline it writes a few bytes to one peripheral register, chosen by a programmable index. Each table entry starts with a header byte that gives a line count and a repeat flag. A fixed number of data bytes follows the header. The engine applies an entry, then holds it for the given number of scanlines before it fetches the next one. The CPU therefore does not need to time these writes.

At the start of each frame, when vertical blanking ends, the engine samples its enable and target index and reloads the table pointer from the base address. It then prefetches the first entry while the first line is still being drawn. Each hblank strobe then causes a burst of writes, or no writes, depending on the entry in force. A header whose count is zero ends the table. The engine then stays quiet until the next frame.

Top module: `hblank_table_writer`

## Requirements
- R1: While reset is asserted, `reg_wr` and `tbl_rd` are low.
- R2: An entry is one header byte followed by NB data bytes at consecutive addresses. Header bits 6:0 hold the line count and bit 7 holds the repeat flag. The data bytes are written in ascending address order.
- R3: Every write carries the target index sampled at the start of the frame. Changing `target_idx` later in the frame has no effect on that frame.
- R4: With the repeat flag set (bit 7 = 1), the entry's data is written on every one of its count lines.
- R5: With the repeat flag clear (bit 7 = 0), the data is written on the first line of the count only. The remaining count−1 lines produce no writes.
- R6: When the count of an entry runs out, the next entry is read and takes effect on the following line.
- R7: A header with count 0 ends the table. There are no further writes and no further table reads until the next frame.
- R8: On the transition from vblank to active (`vblank` goes from 1 to 0), the table pointer reloads from `base_addr`. Each frame therefore replays its table from the start.
- R9: `enable` is sampled only at the start of the frame. A frame that starts disabled performs no reads and no writes, even if `enable` rises mid-frame.
- R10: A line's writes form a burst of exactly NB consecutive cycles that begins in the cycle after the hblank strobe.
- R11: While `vblank` is high the engine is idle. An hblank strobe in vertical blanking causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable, sampled at frame start |
| base_addr | input | AW | Table start address |
| target_idx | input | IW | Destination register index, sampled at frame start |
| vblank | input | 1 | Vertical blanking level |
| hblank | input | 1 | One-cycle strobe at the end of each scanline |
| tbl_rd | output | 1 | Table read request |
| tbl_addr | output | AW | Table read address |
| tbl_data | input | 8 | Table read data, valid one cycle after `tbl_rd` |
| reg_wr | output | 1 | Register write strobe |
| reg_idx | output | IW | Register index of the write |
| reg_data | output | 8 | Register write data |

## Verification
A wrong line counter or repeat flag shows at the ports within the scanline in which it goes wrong. The burst after that hblank has the wrong length, carries the wrong data, or is missing. A wrong table pointer shows one line later, when the next entry's data is written, and also as a wrong total number of table reads per frame. Stale frame-start state shows on the first line of the next frame, which must repeat the previous frame's writes exactly.

// File: rtl/hblank_table_writer.sv
module hblank_table_writer #(
  parameter int AW = 16,
  parameter int IW = 8,
  parameter int NB = 2,
  localparam int KW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [AW-1:0] base_addr,
  input  logic [IW-1:0] target_idx,
  input  logic          vblank,
  input  logic          hblank,
  output logic          tbl_rd,
  output logic [AW-1:0] tbl_addr,
  input  logic [7:0]    tbl_data,
  output logic          reg_wr,
  output logic [IW-1:0] reg_idx,
  output logic [7:0]    reg_data
);
  localparam logic [KW-1:0] KLAST = KW'(NB);
  localparam logic [KW-1:0] KEND  = KW'(NB - 1);

  typedef enum logic [2:0] {S_OFF, S_RD, S_CAP, S_WAIT, S_WR, S_ENDL} st_t;

  st_t           st;
  logic          vb_q;
  logic [AW-1:0] ptr;
  logic [6:0]    cnt;
  logic          rep, first;
  logic [KW-1:0] k;
  logic [IW-1:0] idx_q;
  logic [7:0]    dat [NB];

  wire frame_go = vb_q & ~vblank;

  assign tbl_rd   = (st == S_RD);
  assign tbl_addr = ptr;
  assign reg_wr   = (st == S_WR);
  assign reg_idx  = idx_q;
  assign reg_data = dat[k];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_OFF;
      vb_q  <= 1'b0;
      ptr   <= '0;
      cnt   <= '0;
      rep   <= 1'b0;
      first <= 1'b0;
      k     <= '0;
      idx_q <= '0;
      for (int i = 0; i < NB; i++) dat[i] <= '0;
    end else begin
      vb_q <= vblank;
      if (vblank) st <= S_OFF;
      else if (frame_go) begin
        if (enable) begin
          st    <= S_RD;
          ptr   <= base_addr;
          k     <= '0;
          idx_q <= target_idx;
        end else st <= S_OFF;
      end else begin
        case (st)
          S_RD: begin
            ptr <= ptr + 1'b1;
            st  <= S_CAP;
          end
          S_CAP: begin
            if (k == '0) begin
              rep <= tbl_data[7];
              cnt <= tbl_data[6:0];
              if (tbl_data[6:0] == '0) st <= S_OFF;
              else begin
                k  <= 1;
                st <= S_RD;
              end
            end else begin
              dat[k - 1'b1] <= tbl_data;
              if (k == KLAST) begin
                first <= 1'b1;
                st    <= S_WAIT;
              end else begin
                k  <= k + 1'b1;
                st <= S_RD;
              end
            end
          end
          S_WAIT: if (hblank) begin
            k  <= '0;
            st <= (first || rep) ? S_WR : S_ENDL;
          end
          S_WR: begin
            if (k == KEND) st <= S_ENDL;
            else k <= k + 1'b1;
          end
          S_ENDL: begin
            first <= 1'b0;
            cnt   <= cnt - 1'b1;
            if (cnt == 7'd1) begin
              k  <= '0;
              st <= S_RD;
            end else st <= S_WAIT;
          end
          default: st <= S_OFF;
        endcase
      end
    end
  end
endmodule

module hblank_table_writer_chk #(
  parameter int AW = 16,
  parameter int IW = 8,
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vblank,
  input logic          hblank,
  input logic          tbl_rd,
  input logic          reg_wr,
  input logic [IW-1:0] reg_idx
);
  logic [7:0] run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else run <= reg_wr ? run + 1'b1 : 8'd0;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!reg_wr && !tbl_rd));

  a_r10_starts_after_hblank: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> ($past(hblank) || $past(reg_wr)));

  a_r10_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (run < 8'(NB)));

  a_r11_vblank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && $past(vblank)) |-> (!reg_wr && !tbl_rd));

  a_r3_idx_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && $past(reg_wr)) |-> $stable(reg_idx));
endmodule

bind hblank_table_writer hblank_table_writer_chk #(.AW(AW), .IW(IW), .NB(NB)) u_chk (.*);

// File: tb/hblank_table_writer_tb.sv
`timescale 1ns/1ps
module hblank_table_writer_tb;
  localparam int AW = 16, IW = 8, NB = 2;

  logic clk = 0, rst_n = 0, enable = 0, vblank = 1, hblank = 0;
  logic [AW-1:0] base_addr = '0;
  logic [IW-1:0] target_idx = '0;
  logic tbl_rd, reg_wr;
  logic [AW-1:0] tbl_addr;
  logic [7:0] tbl_data, reg_data;
  logic [IW-1:0] reg_idx;

  always #2.5 clk = ~clk;

  hblank_table_writer #(.AW(AW), .IW(IW), .NB(NB)) u_dut (.*);

  logic [7:0] mem [64];
  always_ff @(posedge clk) if (tbl_rd) tbl_data <= mem[tbl_addr[5:0]];

  int checks = 0, fails = 0;
  int wn = 0, rn = 0;
  logic [7:0] wbuf [8];
  logic [IW-1:0] ibuf [8];

  always @(negedge clk) begin
    if (reg_wr) begin
      if (wn < 8) begin wbuf[wn] = reg_data; ibuf[wn] = reg_idx; end
      wn++;
    end
    if (tbl_rd) rn++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic pulse_line();
    wn = 0;
    @(negedge clk) hblank = 1;
    @(negedge clk) hblank = 0;
    repeat (12) @(negedge clk);
  endtask

  // Model state
  int p, cnt, erd;
  bit rep, first, done;
  logic [7:0] d0, d1;

  task automatic load();
    cnt = mem[p][6:0]; rep = mem[p][7]; first = 1; erd++;
    if (cnt == 0) done = 1;
    else begin d0 = mem[p+1]; d1 = mem[p+2]; erd += NB; p += NB + 1; end
  endtask

  task automatic run_frame(input int base, input bit en, input logic [7:0] tgt, input int nlines);
    int expn;
    @(negedge clk) vblank = 1;
    repeat (3) @(negedge clk);
    wn = 0; pulse_line();
    check(wn == 0, "R11", wn, 0);
    enable = en; target_idx = tgt; base_addr = AW'(base);
    @(negedge clk) vblank = 0;
    rn = 0;
    repeat (10) @(negedge clk);
    enable = ~en; target_idx = ~tgt;
    p = base; erd = 0; done = !en;
    if (en) load();
    for (int l = 0; l < nlines; l++) begin
      pulse_line();
      expn = (!done && (first || rep)) ? NB : 0;
      check(wn == expn, rep ? "R4" : "R5", wn, expn);
      if (expn == NB && wn == NB) begin
        check(wbuf[0] == d0, "R2", wbuf[0], d0);
        check(wbuf[1] == d1, "R2", wbuf[1], d1);
        check(ibuf[0] == tgt && ibuf[1] == tgt, "R3", ibuf[0], tgt);
      end
      if (!done) begin
        first = 0; cnt--;
        if (cnt == 0) load();
      end
    end
    check(rn == erd, en ? "R7" : "R9", rn, erd);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    // table at 0: repeat 3, once 2, repeat 1, end
    mem[0] = 8'h83; mem[1] = 8'hA1; mem[2] = 8'hA2;
    mem[3] = 8'h02; mem[4] = 8'hB1; mem[5] = 8'hB2;
    mem[6] = 8'h81; mem[7] = 8'hC1; mem[8] = 8'hC2;
    mem[9] = 8'h00;
    // table at 12: once 4, repeat 2, end
    mem[12] = 8'h04; mem[13] = 8'h11; mem[14] = 8'h22;
    mem[15] = 8'h82; mem[16] = 8'h33; mem[17] = 8'h44;
    mem[18] = 8'h00;
    mem[40] = 8'h00;

    repeat (3) @(negedge clk);
    check(!reg_wr && !tbl_rd, "R1", reg_wr, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    run_frame(0, 1, 8'h5A, 9);   // R6 entry chaining, R7 end
    run_frame(0, 1, 8'h21, 9);   // R8 replay from base
    run_frame(12, 1, 8'h7E, 8);
    run_frame(12, 1, 8'h7E, 3);  // frame cut mid-entry
    run_frame(12, 1, 8'h13, 8);  // R8 restart after cut
    run_frame(0, 0, 8'h44, 5);   // R9 disabled frame
    run_frame(40, 1, 8'h01, 3);  // R7 immediate end
    for (int r = 0; r < 2; r++)
      for (int c = 1; c <= 6; c++) begin
        mem[48] = 8'((r << 7) | c); mem[49] = 8'(c * 16 + r); mem[50] = 8'(255 - c);
        mem[51] = 8'h00;
        run_frame(48, 1, 8'(c + 16 * r), 8);
      end
    finish_up();
  end
endmodule